// File: doc/BRIEF.md
# Shared display-identification memory with per-input overlays

The block holds one display-identification image that three display inputs read at the same time. Every input sees the same 253 common bytes, but each one also owns three private bytes: a two-byte physical address and a one-byte checksum. Those private bytes are returned to that input only, in place of common data, at locations chosen by a host-programmed pointer and at the top offset. This lets a single image serve several inputs that each need their own address and checksum.

A host loads the image through a write port. The host writes the common bytes, the pointer and the per-input bytes, then pulses a load-done strobe. Storage is volatile, so every reset clears the image-valid flag and forces a reload. Each input has its own read port and its own enable. A read request is accepted on every cycle. Its byte comes back on the next cycle, together with a response-valid pulse. The block has no ready signals and never applies back-pressure: a consumer must take each response in the cycle it appears. All three ports work in parallel and never stall one another. Host writes to any input's private bytes may happen while reads are in flight.

Top module: `edid_share_mem`

## Requirements
- R1: After reset `rsp_vld` is all zero and `image_ok` is 0. Until `image_ok` is 1, every read returns 0xFF, even at locations the host has already written.
- R2: A request with `rd_vld[p]` high in cycle t gives `rsp_vld[p]` high in cycle t+1 with its byte on `rsp_data[p]`. A cycle with no request gives no response.
- R3: A read at offset 0..252 that is neither 255 nor an overlay location returns the byte the host last wrote at host address equal to that offset.
- R4: A read at offset 255 returns that port's own checksum. For port p the checksum sits at host address 256+3p.
- R5: The pointer lives at host address 253 and resets to 0. A read at offset `pointer` returns the port's physical-address high byte (host address 254+3p). A read at offset `pointer+1`, taken modulo 256, returns the low byte (host address 255+3p).
- R6: A port whose `port_en` bit is 0 returns 0xFF for every offset. The other ports are not affected.
- R7: Offsets 253 and 254 return 0xFF when they are not overlay locations.
- R8: Host writes to addresses 263 and above change no byte that any port can read.
- R9: All three ports can request different offsets in the same cycle, and each gets its own correct byte one cycle later.
- R10: A host write to one port's private bytes leaves the other ports' reads unchanged. A read in the same cycle as a write to the location it reads returns the value held before that write.
- R11: Offset 255 always returns the checksum, even when the pointer or pointer+1 lands on 255.
- R12: `image_ok` is set one cycle after `load_done` is pulsed. It then stays set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_vld | input | 1 | Host write strobe |
| wr_addr | input | 9 | Host address: 0-252 common, 253 pointer, 254-262 per-input bytes |
| wr_data | input | 8 | Host write byte |
| load_done | input | 1 | Marks the image as fully programmed |
| port_en | input | 3 | Per-input service enable |
| rd_vld | input | 3 | Per-port read request |
| rd_addr | input | 3x8 | Per-port read offset |
| rsp_vld | output | 3 | Per-port response valid, one cycle after the request |
| rsp_data | output | 3x8 | Per-port response byte |
| image_ok | output | 1 | Image-valid flag |

## Verification
The bench tests the pointer's edge positions.

- With the pointer at 254, offset 255 must still give the checksum. A design with the priority inverted would return the physical-address low byte there instead.
- Out-of-range host writes at 263 and 300 are checked against the bytes they could alias to. A decoder that drops the top address bit would corrupt common bytes 7 and 44.
- A checksum rewrite issued in the same cycle as reads on all three ports must leave the reads unaffected. A design that forwards the write or decodes the port wrongly would return a new byte, or the wrong port's byte.
- A disabled middle port, reads at offsets 253 and 254, and reads made before the load-done strobe must all return 0xFF. A design that let garbage through in any of these cases would fail these checks.

// File: rtl/edid_share_pkg.sv
package edid_share_pkg;
  localparam int unsigned BYTE_W = 8;

  // private bytes of one input, selected by field code 0/1/2
  typedef struct packed {
    logic [BYTE_W-1:0] pa_hi;
    logic [BYTE_W-1:0] pa_lo;
    logic [BYTE_W-1:0] csum;
  } ovl_t;

  localparam logic [1:0] FLD_HI  = 2'd0;
  localparam logic [1:0] FLD_LO  = 2'd1;
  localparam logic [1:0] FLD_SUM = 2'd2;
  localparam logic [BYTE_W-1:0] BLANK = {BYTE_W{1'b1}};
endpackage

// File: rtl/edid_host_decode.sv
module edid_host_decode
  import edid_share_pkg::*;
#(
  parameter int unsigned NPORT        = 3,
  parameter int unsigned SHARED_BYTES = 253,
  parameter int unsigned HADDR_W      = 9
) (
  input  logic               wr_vld,
  input  logic [HADDR_W-1:0] wr_addr,
  output logic               shared_we,
  output logic               ptr_we,
  output logic [NPORT-1:0]   ovl_we,
  output logic [1:0]         ovl_field
);
  localparam int unsigned PTR_ADDR = SHARED_BYTES;
  localparam int unsigned OVL_BASE = SHARED_BYTES + 1;

  assign shared_we = wr_vld && (wr_addr < HADDR_W'(SHARED_BYTES));
  assign ptr_we    = wr_vld && (wr_addr == HADDR_W'(PTR_ADDR));

  always_comb begin
    ovl_we    = '0;
    ovl_field = FLD_HI;
    for (int p = 0; p < int'(NPORT); p++) begin
      if (wr_addr >= HADDR_W'(OVL_BASE + 3*p) &&
          wr_addr <  HADDR_W'(OVL_BASE + 3*p + 3)) begin
        ovl_we[p] = wr_vld;
        ovl_field = 2'(wr_addr - HADDR_W'(OVL_BASE + 3*p));
      end
    end
  end
endmodule

// File: rtl/edid_shared_store.sv
module edid_shared_store
  import edid_share_pkg::*;
#(
  parameter int unsigned NPORT        = 3,
  parameter int unsigned SHARED_BYTES = 253,
  parameter int unsigned ADDR_W       = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          shared_we,
  input  logic [ADDR_W-1:0]             wr_idx,
  input  logic [BYTE_W-1:0]             wr_data,
  input  logic                          ptr_we,
  input  logic [NPORT-1:0]              ovl_we,
  input  logic [1:0]                    ovl_field,
  input  logic [NPORT-1:0][ADDR_W-1:0]  rd_addr,
  output logic [NPORT-1:0][BYTE_W-1:0]  shared_q,
  output logic [ADDR_W-1:0]             ptr_q,
  output ovl_t [NPORT-1:0]              ovl_q
);
  // volatile common bytes: not reset, guarded by the image-valid flag
  logic [BYTE_W-1:0] mem [SHARED_BYTES];

  always_ff @(posedge clk) begin
    if (shared_we) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (ptr_we) ptr_q <= wr_data[ADDR_W-1:0];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_ovl
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ovl_q[p] <= {3{BLANK}};
      end else if (ovl_we[p]) begin
        unique case (ovl_field)
          FLD_HI:  ovl_q[p].pa_hi <= wr_data;
          FLD_LO:  ovl_q[p].pa_lo <= wr_data;
          default: ovl_q[p].csum  <= wr_data;
        endcase
      end
    end

    assign shared_q[p] = (rd_addr[p] < ADDR_W'(SHARED_BYTES)) ? mem[rd_addr[p]] : BLANK;
  end
endmodule

// File: rtl/edid_read_port.sv
module edid_read_port
  import edid_share_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              enable,
  input  logic              loaded,
  input  logic [ADDR_W-1:0] ptr,
  input  ovl_t              ovl,
  input  logic [BYTE_W-1:0] shared_byte,
  output logic              rsp_vld,
  output logic [BYTE_W-1:0] rsp_data
);
  localparam logic [ADDR_W-1:0] SUM_OFS = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] ptr_nx;
  logic [BYTE_W-1:0] pick;

  assign ptr_nx = ptr + ADDR_W'(1);

  // checksum slot outranks both pointer slots
  always_comb begin
    if (!enable || !loaded)         pick = BLANK;
    else if (req_addr == SUM_OFS)   pick = ovl.csum;
    else if (req_addr == ptr)       pick = ovl.pa_hi;
    else if (req_addr == ptr_nx)    pick = ovl.pa_lo;
    else                            pick = shared_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld  <= 1'b0;
      rsp_data <= BLANK;
    end else begin
      rsp_vld <= req_vld;
      if (req_vld) rsp_data <= pick;
    end
  end
endmodule

// File: rtl/edid_share_mem.sv
module edid_share_mem
  import edid_share_pkg::*;
#(
  parameter int unsigned NPORT        = 3,
  parameter int unsigned SHARED_BYTES = 253,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned HADDR_W      = $clog2(SHARED_BYTES + 1 + 3*NPORT)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_vld,
  input  logic [HADDR_W-1:0]           wr_addr,
  input  logic [7:0]                   wr_data,
  input  logic                         load_done,
  input  logic [NPORT-1:0]             port_en,
  input  logic [NPORT-1:0]             rd_vld,
  input  logic [NPORT-1:0][ADDR_W-1:0] rd_addr,
  output logic [NPORT-1:0]             rsp_vld,
  output logic [NPORT-1:0][7:0]        rsp_data,
  output logic                         image_ok
);
  logic                        shared_we, ptr_we;
  logic [NPORT-1:0]            ovl_we;
  logic [1:0]                  ovl_field;
  logic [NPORT-1:0][7:0]       shared_q;
  logic [ADDR_W-1:0]           ptr_q;
  ovl_t [NPORT-1:0]            ovl_q;

  edid_host_decode #(.NPORT(NPORT), .SHARED_BYTES(SHARED_BYTES), .HADDR_W(HADDR_W)) dec_i (
    .wr_vld(wr_vld), .wr_addr(wr_addr), .shared_we(shared_we),
    .ptr_we(ptr_we), .ovl_we(ovl_we), .ovl_field(ovl_field)
  );

  edid_shared_store #(.NPORT(NPORT), .SHARED_BYTES(SHARED_BYTES), .ADDR_W(ADDR_W)) store_i (
    .clk(clk), .rst_n(rst_n), .shared_we(shared_we), .wr_idx(wr_addr[ADDR_W-1:0]),
    .wr_data(wr_data), .ptr_we(ptr_we), .ovl_we(ovl_we), .ovl_field(ovl_field),
    .rd_addr(rd_addr), .shared_q(shared_q), .ptr_q(ptr_q), .ovl_q(ovl_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         image_ok <= 1'b0;
    else if (load_done) image_ok <= 1'b1;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    edid_read_port #(.ADDR_W(ADDR_W)) rp_i (
      .clk(clk), .rst_n(rst_n), .req_vld(rd_vld[p]), .req_addr(rd_addr[p]),
      .enable(port_en[p]), .loaded(image_ok), .ptr(ptr_q), .ovl(ovl_q[p]),
      .shared_byte(shared_q[p]), .rsp_vld(rsp_vld[p]), .rsp_data(rsp_data[p])
    );
  end
endmodule

// File: rtl/edid_share_mem_chk.sv
module edid_share_mem_chk #(
  parameter int unsigned NPORT  = 3,
  parameter int unsigned ADDR_W = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         load_done,
  input logic [NPORT-1:0]             port_en,
  input logic [NPORT-1:0]             rd_vld,
  input logic [NPORT-1:0][ADDR_W-1:0] rd_addr,
  input logic [NPORT-1:0]             rsp_vld,
  input logic [NPORT-1:0][7:0]        rsp_data,
  input logic                         image_ok
);
  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rsp_vld == $past(rd_vld));

  p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    image_ok |=> image_ok);

  p_flag_needs_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(image_ok) |-> $past(load_done));

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    p_unloaded_blank_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vld[p] && !image_ok) |=> rsp_data[p] == 8'hFF);

    p_disabled_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vld[p] && !port_en[p]) |=> rsp_data[p] == 8'hFF);

    p_gap_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vld[p] && (rd_addr[p] == ADDR_W'(253)) && !image_ok) |=> rsp_vld[p] && rsp_data[p] == 8'hFF);
  end
endmodule

bind edid_share_mem edid_share_mem_chk #(.NPORT(NPORT), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .load_done(load_done), .port_en(port_en),
  .rd_vld(rd_vld), .rd_addr(rd_addr), .rsp_vld(rsp_vld), .rsp_data(rsp_data),
  .image_ok(image_ok)
);

// File: tb/edid_share_mem_tb.sv
`timescale 1ns/1ps
module edid_share_mem_tb_top;
  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_vld = 1'b0;
  logic [8:0]      wr_addr = '0;
  logic [7:0]      wr_data = '0;
  logic            load_done = 1'b0;
  logic [2:0]      port_en = 3'b111;
  logic [2:0]      rd_vld = '0;
  logic [2:0][7:0] rd_addr = '0;
  logic [2:0]      rsp_vld;
  logic [2:0][7:0] rsp_data;
  logic            image_ok;

  int checks = 0;
  int errors = 0;

  // bench-side picture of what the host has programmed
  logic [7:0] m_mem [253];
  logic [7:0] m_ptr;
  logic [7:0] m_hi [3];
  logic [7:0] m_lo [3];
  logic [7:0] m_sum [3];
  logic       m_ok;

  always #2 clk = ~clk;

  edid_share_mem dut_i (
    .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_done(load_done), .port_en(port_en), .rd_vld(rd_vld), .rd_addr(rd_addr),
    .rsp_vld(rsp_vld), .rsp_data(rsp_data), .image_ok(image_ok)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(int p, int a);
    if (!port_en[p] || !m_ok) return 8'hFF;
    if (a == 255) return m_sum[p];
    if (a == int'(m_ptr)) return m_hi[p];
    if (a == ((int'(m_ptr) + 1) % 256)) return m_lo[p];
    if (a < 253) return m_mem[a];
    return 8'hFF;
  endfunction

  task automatic model_wr(int a, logic [7:0] d);
    if (a < 253) m_mem[a] = d;
    else if (a == 253) m_ptr = d;
    else if (a < 263) begin
      case ((a - 254) % 3)
        0: m_hi[(a - 254) / 3] = d;
        1: m_lo[(a - 254) / 3] = d;
        default: m_sum[(a - 254) / 3] = d;
      endcase
    end
  endtask

  task automatic host_wr(int a, logic [7:0] d);
    @(negedge clk);
    wr_vld = 1'b1; wr_addr = 9'(a); wr_data = d;
    @(negedge clk);
    wr_vld = 1'b0;
    model_wr(a, d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rd_vld = '0; wr_vld = 1'b0; load_done = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_ok = 1'b0; m_ptr = 8'd0;
    for (int p = 0; p < 3; p++) begin m_hi[p] = 8'hFF; m_lo[p] = 8'hFF; m_sum[p] = 8'hFF; end
  endtask

  // one request on every port in the same cycle, checked one cycle later
  task automatic read3(string tag, int a0, int a1, int a2);
    logic [7:0] e [3];
    @(negedge clk);
    rd_addr[0] = 8'(a0); rd_addr[1] = 8'(a1); rd_addr[2] = 8'(a2); rd_vld = 3'b111;
    e[0] = exp_rd(0, a0); e[1] = exp_rd(1, a1); e[2] = exp_rd(2, a2);
    @(negedge clk);
    rd_vld = '0;
    for (int p = 0; p < 3; p++) begin
      chk({tag, " vld"}, {7'd0, rsp_vld[p]}, 8'd1);
      chk(tag, rsp_data[p], e[p]);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 image_ok after reset", {7'd0, image_ok}, 8'd0);
    chk("R1 rsp_vld after reset", {5'd0, rsp_vld}, 8'd0);
    host_wr(5, 8'h33);
    read3("R1 read before load", 5, 253, 255);
  endtask

  task automatic t_load();
    for (int i = 0; i < 253; i++) host_wr(i, 8'(i) ^ 8'h5A);
    host_wr(253, 8'd100);
    for (int p = 0; p < 3; p++) begin
      host_wr(254 + 3*p, 8'h10 + 8'(p));
      host_wr(255 + 3*p, 8'h20 + 8'(p));
      host_wr(256 + 3*p, 8'hC0 + 8'(p));
    end
    @(negedge clk); load_done = 1'b1;
    @(negedge clk); load_done = 1'b0; m_ok = 1'b1;
    chk("R12 image_ok set by strobe", {7'd0, image_ok}, 8'd1);
    repeat (3) @(negedge clk);
    chk("R12 image_ok holds", {7'd0, image_ok}, 8'd1);
  endtask

  task automatic t_latency();
    @(negedge clk);
    rd_vld = 3'b010; rd_addr[1] = 8'd3;
    @(negedge clk);
    rd_vld = '0;
    chk("R2 response one cycle later", {5'd0, rsp_vld}, 8'b010);
    chk("R2 response data", rsp_data[1], 8'(3) ^ 8'h5A);
    @(negedge clk);
    chk("R2 no request no response", {5'd0, rsp_vld}, 8'd0);
  endtask

  task automatic t_shared();
    read3("R3 R9 common bytes", 0, 50, 252);
    read3("R9 mixed offsets", 99, 102, 7);
  endtask

  task automatic t_overlay();
    read3("R5 pa high", 100, 100, 100);
    read3("R5 pa low", 101, 101, 101);
    read3("R4 checksum", 255, 255, 255);
  endtask

  task automatic t_gap();
    read3("R7 unmapped offsets", 253, 254, 253);
  endtask

  task automatic t_disable();
    port_en = 3'b101;
    read3("R6 middle port off", 10, 10, 10);
    read3("R6 off port overlay", 255, 255, 100);
    port_en = 3'b111;
  endtask

  task automatic t_outrange();
    host_wr(263, 8'h00);
    host_wr(300, 8'h00);
    host_wr(511, 8'h00);
    read3("R8 alias targets unchanged", 7, 44, 255);
    read3("R8 pointer slots unchanged", 100, 101, 253);
  endtask

  task automatic t_rewrite();
    logic [7:0] e [3];
    @(negedge clk);
    rd_vld = 3'b111; rd_addr[0] = 8'd255; rd_addr[1] = 8'd255; rd_addr[2] = 8'd100;
    wr_vld = 1'b1; wr_addr = 9'd256; wr_data = 8'hE7;
    e[0] = exp_rd(0, 255); e[1] = exp_rd(1, 255); e[2] = exp_rd(2, 100);
    @(negedge clk);
    rd_vld = '0; wr_vld = 1'b0;
    model_wr(256, 8'hE7);
    for (int p = 0; p < 3; p++) chk("R10 read during overlay write", rsp_data[p], e[p]);
    read3("R10 new checksum only on port 0", 255, 255, 255);
  endtask

  task automatic t_ptr_edge();
    host_wr(253, 8'd254);
    read3("R11 checksum wins over pointer+1", 255, 255, 255);
    read3("R5 moved pointer high", 254, 254, 254);
    read3("R5 old pointer now common", 100, 101, 100);
  endtask

  task automatic t_reset_again();
    do_reset();
    chk("R1 R12 flag cleared by reset", {7'd0, image_ok}, 8'd0);
    read3("R1 blank after reset", 0, 255, 254);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_latency();
    t_shared();
    t_overlay();
    t_gap();
    t_disable();
    t_outrange();
    t_rewrite();
    t_ptr_edge();
    t_reset_again();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule